// File: doc/BRIEF.md
# Dual Flash Memory Lane Router

This block sits between the byte-level serial engine of a quad-SPI controller and two identical flash devices. It routes chip selects and the 4-bit IO lanes for three connection modes: one device only, two devices stacked on a shared bus, and two devices on separate parallel buses. The controller opens a transfer with a single transfer-active signal. It then hands over one byte at a time together with a direction. The block turns each byte into lane beats, and for reads it hands back whole bytes.

In stacked mode a page bit picks which of the two devices the shared lanes and the only asserted chip select belong to. In parallel mode both devices are selected together. Each byte is split bitwise: even-indexed bits go to the lower device and odd-indexed bits go to the upper device, so a byte moves in a single beat. Reads rebuild the byte with the exact inverse of that split.

Top module: `qspi_dual_lane_router`

## Requirements
- R1: Mode decode uses configuration bit 30 (two devices), bit 29 (separate buses) and bit 28 (upper page). With bit 30 clear, the mode is single-device on the lower port, whatever bits 29 and 28 hold. With bit 30 set and bit 29 clear, the mode is stacked. With both bits set, the mode is parallel.
- R2: Chip selects are active low. A chip select can go low only in the cycle after a clock edge at which `xfer_active` was high. Both chip selects are high one cycle after `xfer_active` falls, and both are high out of reset.
- R3: In stacked mode only the device chosen by bit 28 has its chip select low (lower device when the bit is 0, upper device when it is 1). The other chip select stays high for the whole transfer. Single mode asserts only `lo_cs_n`.
- R4: In parallel mode both `lo_cs_n` and `up_cs_n` are low for the whole transfer.
- R5: The configuration is captured at the clock edge that opens a transfer. Changes to `cfg_word` while the transfer is open change neither the chip selects nor the lane routing.
- R6: In single and stacked modes, a write byte takes two beats on the selected port. Beat 0 carries bits [7:4] and beat 1 carries bits [3:0], with `*_io_oe` = 4'hF during both beats.
- R7: In parallel mode, a write byte takes one beat. `lo_io_out` = {b6,b4,b2,b0} and `up_io_out` = {b7,b5,b3,b1}, with both output enables at 4'hF.
- R8: A read byte drives no lane (all output enables 0). In serial modes, `rx_byte` = {beat-0 nibble, beat-1 nibble}, taken only from the selected port. In parallel mode, `rx_byte` puts `lo_io_in[k]` at bit 2k and `up_io_in[k]` at bit 2k+1.
- R9: The lanes of an unselected device are never driven, and no lane is driven outside a byte beat. Output data is 0 whenever the output enable is 0.
- R10: `byte_start` is accepted only inside a transfer and when no byte is in flight. `byte_done` is a one-cycle pulse, 2 cycles after acceptance in serial modes and 1 cycle after acceptance in parallel mode. A `byte_start` that is not accepted has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word; bits 30, 29, 28 select the mode |
| xfer_active | input | 1 | Controller's logical chip select, high while a transfer is open |
| xfer_dir | input | 1 | Byte direction, 1 = write to flash, sampled with `byte_start` |
| byte_start | input | 1 | Start one byte |
| tx_byte | input | 8 | Byte to write |
| rx_byte | output | 8 | Last byte read |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| lo_cs_n | output | 1 | Lower device chip select, active low |
| lo_io_out | output | 4 | Lower device lane data out |
| lo_io_oe | output | 4 | Lower device lane output enables |
| lo_io_in | input | 4 | Lower device lane data in |
| up_cs_n | output | 1 | Upper device chip select, active low |
| up_io_out | output | 4 | Upper device lane data out |
| up_io_oe | output | 4 | Upper device lane output enables |
| up_io_in | input | 4 | Upper device lane data in |

## Verification
On every cycle, the assertions check these properties:
- chip-select idleness after `xfer_active` drops;
- that stacked and single modes never select both devices;
- that the captured mode is stable while a transfer stays open;
- lane quietness for unselected devices, for reads and between bytes;
- that `byte_done` never lasts two cycles.

Only the bench scenarios can show that the correct nibble reaches the correct lanes in the correct beat. The same holds for the bit interleave in both directions, for ignoring a mid-transfer mode change, and for rejecting starts outside a transfer or during a byte.

// File: rtl/qspi_dlr_pkg.sv
package qspi_dlr_pkg;

  typedef enum logic [1:0] {
    ROUTE_SINGLE   = 2'd0,
    ROUTE_STACK_LO = 2'd1,
    ROUTE_STACK_UP = 2'd2,
    ROUTE_PARALLEL = 2'd3
  } route_e;

  // R1: two-device flag wins over the others; separate-bus beats page select
  function automatic route_e decode_route(input logic twin, input logic sepbus,
                                          input logic upage);
    route_e r;
    if (!twin)       r = ROUTE_SINGLE;
    else if (sepbus) r = ROUTE_PARALLEL;
    else if (upage)  r = ROUTE_STACK_UP;
    else             r = ROUTE_STACK_LO;
    return r;
  endfunction

  function automatic logic route_uses_lo(input route_e r);
    return r != ROUTE_STACK_UP;
  endfunction

  function automatic logic route_uses_up(input route_e r);
    return (r == ROUTE_STACK_UP) || (r == ROUTE_PARALLEL);
  endfunction

endpackage

// File: rtl/qspi_dlr_cfg_latch.sv
module qspi_dlr_cfg_latch
  import qspi_dlr_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int TWIN_BIT   = 30,
  parameter int SEPBUS_BIT = 29,
  parameter int UPAGE_BIT  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             in_xfer,
  output route_e           route,
  output logic             lo_cs_n,
  output logic             up_cs_n
);

  logic   open_evt;
  route_e route_next;

  assign open_evt   = xfer_active && !in_xfer;
  assign route_next = decode_route(cfg_word[TWIN_BIT], cfg_word[SEPBUS_BIT],
                                   cfg_word[UPAGE_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer <= 1'b0;
      route   <= ROUTE_SINGLE;
    end else begin
      in_xfer <= xfer_active;
      if (open_evt) route <= route_next;   // R5: captured once per transfer
    end
  end

  assign lo_cs_n = !(in_xfer && route_uses_lo(route));
  assign up_cs_n = !(in_xfer && route_uses_up(route));

  // R2: no select in the cycle after the controller's select was low
  a_r2_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer_active) |-> (lo_cs_n && up_cs_n));

  // R3: non-parallel routes never select both devices
  a_r3_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    (route != ROUTE_PARALLEL) |-> (lo_cs_n || up_cs_n));

  // R5: mode held while the transfer stays open
  a_r5_route_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && $past(in_xfer)) |-> $stable(route));

endmodule

// File: rtl/qspi_dlr_byte_engine.sv
module qspi_dlr_byte_engine #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_xfer,
  input  logic               par_mode,
  input  logic               byte_start,
  input  logic               xfer_dir,
  input  logic [2*LANES-1:0] tx_byte,
  input  logic [LANES-1:0]   sel_in,
  input  logic [LANES-1:0]   lo_in,
  input  logic [LANES-1:0]   up_in,
  output logic               busy,
  output logic               dir_q,
  output logic [LANES-1:0]   ser_nib,
  output logic [LANES-1:0]   par_lo_nib,
  output logic [LANES-1:0]   par_up_nib,
  output logic [2*LANES-1:0] rx_byte,
  output logic               byte_done
);

  localparam int BYTE_W = 2 * LANES;

  function automatic logic [LANES-1:0] even_bits(input logic [BYTE_W-1:0] b);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = b[2*k];
    return r;
  endfunction

  function automatic logic [LANES-1:0] odd_bits(input logic [BYTE_W-1:0] b);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = b[2*k+1];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] weave(input logic [LANES-1:0] ev,
                                              input logic [LANES-1:0] od);
    logic [BYTE_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[2*k]   = ev[k];
      r[2*k+1] = od[k];
    end
    return r;
  endfunction

  logic              beat;
  logic [BYTE_W-1:0] tx_q;
  logic [LANES-1:0]  hi_q;
  logic              accept;
  logic              last_beat;

  assign accept    = byte_start && in_xfer && !busy;
  assign last_beat = busy && (par_mode || beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat      <= 1'b0;
      dir_q     <= 1'b0;
      tx_q      <= '0;
      hi_q      <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!in_xfer) begin
        busy <= 1'b0;
        beat <= 1'b0;
      end else if (accept) begin
        busy  <= 1'b1;
        beat  <= 1'b0;
        dir_q <= xfer_dir;
        tx_q  <= tx_byte;
      end else if (last_beat) begin
        busy      <= 1'b0;
        beat      <= 1'b0;
        byte_done <= 1'b1;
        if (!dir_q) rx_byte <= par_mode ? weave(lo_in, up_in) : {hi_q, sel_in};
      end else if (busy) begin
        beat <= 1'b1;
        hi_q <= sel_in;
      end
    end
  end

  assign ser_nib    = beat ? tx_q[LANES-1:0] : tx_q[BYTE_W-1:LANES];
  assign par_lo_nib = even_bits(tx_q);
  assign par_up_nib = odd_bits(tx_q);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R10: nothing in flight once the transfer has closed
  a_r10_idle_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    !in_xfer |=> !busy);

endmodule

// File: rtl/qspi_dlr_lane_steer.sv
module qspi_dlr_lane_steer
  import qspi_dlr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  route_e           route,
  input  logic             busy,
  input  logic             dir_q,
  input  logic [LANES-1:0] ser_nib,
  input  logic [LANES-1:0] par_lo_nib,
  input  logic [LANES-1:0] par_up_nib,
  input  logic [LANES-1:0] lo_in,
  input  logic [LANES-1:0] up_in,
  output logic [LANES-1:0] lo_out,
  output logic [LANES-1:0] lo_oe,
  output logic [LANES-1:0] up_out,
  output logic [LANES-1:0] up_oe,
  output logic [LANES-1:0] sel_in
);

  localparam logic [LANES-1:0] ALL_ON = '1;

  logic drive;
  assign drive = busy && dir_q;

  always_comb begin
    lo_out = '0;
    lo_oe  = '0;
    up_out = '0;
    up_oe  = '0;
    sel_in = lo_in;
    unique case (route)
      ROUTE_STACK_UP: begin
        sel_in = up_in;
        if (drive) begin
          up_out = ser_nib;
          up_oe  = ALL_ON;
        end
      end
      ROUTE_PARALLEL: begin
        if (drive) begin
          lo_out = par_lo_nib;
          up_out = par_up_nib;
          lo_oe  = ALL_ON;
          up_oe  = ALL_ON;
        end
      end
      default: begin
        if (drive) begin
          lo_out = ser_nib;
          lo_oe  = ALL_ON;
        end
      end
    endcase
  end

endmodule

// File: rtl/qspi_dual_lane_router.sv
module qspi_dual_lane_router
  import qspi_dlr_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int TWIN_BIT   = 30,
  parameter int SEPBUS_BIT = 29,
  parameter int UPAGE_BIT  = 28,
  parameter int LANES      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic               xfer_active,
  input  logic               xfer_dir,
  input  logic               byte_start,
  input  logic [2*LANES-1:0] tx_byte,
  output logic [2*LANES-1:0] rx_byte,
  output logic               byte_done,
  output logic               lo_cs_n,
  output logic [LANES-1:0]   lo_io_out,
  output logic [LANES-1:0]   lo_io_oe,
  input  logic [LANES-1:0]   lo_io_in,
  output logic               up_cs_n,
  output logic [LANES-1:0]   up_io_out,
  output logic [LANES-1:0]   up_io_oe,
  input  logic [LANES-1:0]   up_io_in
);

  logic             in_xfer;
  route_e           route;
  logic             par_mode;
  logic             busy;
  logic             dir_q;
  logic [LANES-1:0] ser_nib, par_lo_nib, par_up_nib, sel_in;

  assign par_mode = (route == ROUTE_PARALLEL);

  qspi_dlr_cfg_latch #(
    .CFG_W(CFG_W), .TWIN_BIT(TWIN_BIT), .SEPBUS_BIT(SEPBUS_BIT), .UPAGE_BIT(UPAGE_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .cfg_word(cfg_word),
    .in_xfer(in_xfer), .route(route), .lo_cs_n(lo_cs_n), .up_cs_n(up_cs_n)
  );

  qspi_dlr_byte_engine #(.LANES(LANES)) u_eng (
    .clk(clk), .rst_n(rst_n), .in_xfer(in_xfer), .par_mode(par_mode),
    .byte_start(byte_start), .xfer_dir(xfer_dir), .tx_byte(tx_byte),
    .sel_in(sel_in), .lo_in(lo_io_in), .up_in(up_io_in),
    .busy(busy), .dir_q(dir_q), .ser_nib(ser_nib),
    .par_lo_nib(par_lo_nib), .par_up_nib(par_up_nib),
    .rx_byte(rx_byte), .byte_done(byte_done)
  );

  qspi_dlr_lane_steer #(.LANES(LANES)) u_steer (
    .route(route), .busy(busy), .dir_q(dir_q), .ser_nib(ser_nib),
    .par_lo_nib(par_lo_nib), .par_up_nib(par_up_nib),
    .lo_in(lo_io_in), .up_in(up_io_in),
    .lo_out(lo_io_out), .lo_oe(lo_io_oe), .up_out(up_io_out), .up_oe(up_io_oe),
    .sel_in(sel_in)
  );

  // R9: upper lanes silent when the upper device is not routed
  a_r9_up_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_SINGLE || route == ROUTE_STACK_LO) |-> (up_io_oe == '0));

  a_r9_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_STACK_UP) |-> (lo_io_oe == '0));

  // R9: no lane driven between bytes
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lo_io_oe == '0 && up_io_oe == '0));

  // R8: reads never drive
  a_r8_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_q) |-> (lo_io_oe == '0 && up_io_oe == '0));

  // R7: parallel write drives both ports
  a_r7_par_both: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_q && par_mode) |-> (&lo_io_oe && &up_io_oe));

endmodule

// File: tb/sim_qspi_dual_lane_router.sv
module sim_qspi_dual_lane_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        xfer_active = 1'b0, xfer_dir = 1'b0, byte_start = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic [7:0]  rx_byte;
  logic        byte_done, lo_cs_n, up_cs_n;
  logic [3:0]  lo_io_out, lo_io_oe, up_io_out, up_io_oe;
  logic [3:0]  lo_io_in = '0, up_io_in = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  qspi_dual_lane_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .xfer_active(xfer_active),
    .xfer_dir(xfer_dir), .byte_start(byte_start), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .byte_done(byte_done),
    .lo_cs_n(lo_cs_n), .lo_io_out(lo_io_out), .lo_io_oe(lo_io_oe), .lo_io_in(lo_io_in),
    .up_cs_n(up_cs_n), .up_io_out(up_io_out), .up_io_oe(up_io_oe), .up_io_in(up_io_in)
  );

  // {twin, sepbus, upage, dir, data}
  localparam logic [11:0] VEC [0:10] = '{
    {3'b000, 1'b1, 8'hA5}, {3'b011, 1'b0, 8'h3C}, {3'b100, 1'b1, 8'h96},
    {3'b101, 1'b1, 8'h5A}, {3'b101, 1'b0, 8'hC3}, {3'b100, 1'b0, 8'h71},
    {3'b110, 1'b1, 8'hB4}, {3'b111, 1'b1, 8'h01}, {3'b110, 1'b0, 8'hE8},
    {3'b111, 1'b0, 8'h80}, {3'b010, 1'b0, 8'h0F}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_of(input logic [2:0] m);
    return {1'b0, m, 28'h0};
  endfunction

  task automatic open_xfer(input logic [2:0] m);
    @(negedge clk);
    cfg_word = cfg_of(m);
    xfer_active = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_xfer;
    xfer_active = 1'b0;
    @(negedge clk);
    check(lo_cs_n && up_cs_n, "R2 close", {up_cs_n, lo_cs_n}, 2'b11);
  endtask

  // m is the mode the design should be using; called at a negedge inside a transfer
  task automatic do_byte(input logic [2:0] m, input logic dir, input logic [7:0] d);
    bit par, useup;
    logic [3:0] ev, od, nib;
    par   = m[2] && m[1];
    useup = m[2] && !m[1] && m[0];
    for (int k = 0; k < 4; k++) begin
      ev[k] = d[2*k];
      od[k] = d[2*k+1];
    end
    // R3/R4: chip selects for this mode
    if (par) check(!lo_cs_n && !up_cs_n, "R4 cs", {up_cs_n, lo_cs_n}, 2'b00);
    else if (useup) check(lo_cs_n && !up_cs_n, "R3 cs", {up_cs_n, lo_cs_n}, 2'b01);
    else check(!lo_cs_n && up_cs_n, "R1/R3 cs", {up_cs_n, lo_cs_n}, 2'b10);
    byte_start = 1'b1; xfer_dir = dir; tx_byte = d;
    @(negedge clk);
    byte_start = 1'b0; tx_byte = 8'h00;
    if (par) begin
      if (dir) begin
        check(lo_io_out == ev && up_io_out == od && lo_io_oe == 4'hF && up_io_oe == 4'hF,
              "R7 split", {lo_io_oe, up_io_oe, lo_io_out, up_io_out}, {8'hFF, ev, od});
      end else begin
        check(lo_io_oe == 0 && up_io_oe == 0, "R8 par oe", {lo_io_oe, up_io_oe}, 0);
        lo_io_in = ev; up_io_in = od;
      end
      @(negedge clk);
    end else begin
      for (int b = 0; b < 2; b++) begin
        nib = (b == 0) ? d[7:4] : d[3:0];
        if (dir) begin
          if (useup)
            check(up_io_out == nib && up_io_oe == 4'hF && lo_io_oe == 0, "R6 up beat",
                  {lo_io_oe, up_io_oe, up_io_out}, {8'h0F, nib});
          else
            check(lo_io_out == nib && lo_io_oe == 4'hF && up_io_oe == 0, "R6/R9 lo beat",
                  {up_io_oe, lo_io_oe, lo_io_out}, {8'h0F, nib});
        end else begin
          check(lo_io_oe == 0 && up_io_oe == 0, "R8 ser oe", {lo_io_oe, up_io_oe}, 0);
          if (useup) begin up_io_in = nib; lo_io_in = ~nib; end
          else begin lo_io_in = nib; up_io_in = ~nib; end
        end
        @(negedge clk);
      end
    end
    check(byte_done == 1'b1, "R10 done", byte_done, 1);
    if (!dir) check(rx_byte == d, "R8 rx", rx_byte, d);
    lo_io_in = '0; up_io_in = '0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lo_cs_n && up_cs_n && lo_io_oe == 0 && up_io_oe == 0 && !byte_done,
          "R2 reset", {lo_cs_n, up_cs_n, lo_io_oe, up_io_oe, byte_done}, 11'h600);

    foreach (VEC[i]) begin
      open_xfer(VEC[i][11:9]);
      do_byte(VEC[i][11:9], VEC[i][8], VEC[i][7:0]);
      close_xfer();
    end

    // R5: mode change inside a transfer is ignored
    open_xfer(3'b100);
    cfg_word = cfg_of(3'b111);
    @(negedge clk);
    do_byte(3'b100, 1'b1, 8'h3E);
    cfg_word = cfg_of(3'b101);
    @(negedge clk);
    do_byte(3'b100, 1'b0, 8'h9B);
    close_xfer();

    // R10: back-to-back bytes on the upper device
    open_xfer(3'b101);
    do_byte(3'b101, 1'b1, 8'h27);
    do_byte(3'b101, 1'b0, 8'hD4);
    close_xfer();

    // R10: start outside a transfer has no effect
    @(negedge clk);
    byte_start = 1'b1; xfer_dir = 1'b1; tx_byte = 8'hFF;
    @(negedge clk);
    byte_start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(!byte_done && lo_io_oe == 0 && up_io_oe == 0 && lo_cs_n && up_cs_n,
            "R10 idle start", {byte_done, lo_io_oe, up_io_oe}, 0);
      @(negedge clk);
    end

    // R10: start during a byte is ignored
    open_xfer(3'b100);
    byte_start = 1'b1; xfer_dir = 1'b1; tx_byte = 8'h6D;
    @(negedge clk);
    tx_byte = 8'hF0;
    check(lo_io_out == 4'h6 && lo_io_oe == 4'hF, "R10 busy beat0", lo_io_out, 4'h6);
    @(negedge clk);
    byte_start = 1'b0;
    check(lo_io_out == 4'hD, "R10 busy beat1", lo_io_out, 4'hD);
    @(negedge clk);
    check(byte_done, "R10 busy done", byte_done, 1);
    @(negedge clk);
    check(!byte_done && lo_io_oe == 0, "R10 no second byte", {byte_done, lo_io_oe}, 0);
    close_xfer();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule